// File: doc/BRIEF.md
# XGMII Link Fault Signaling Unit

This block sits between a 10G MAC and a 32-bit XGMII (four byte lanes, one control bit per lane, one column per clock). On the receive side it inspects every column for fault sequence ordered sets. It tells local faults apart from remote faults, declares a fault once enough matching sequences arrive close together, and withdraws it after a long quiet stretch. The result is reported to client logic as a two-bit status.

On the transmit side it registers the client's column onto the XGMII. While a fault is active it replaces the client column according to the received fault type. A received local fault makes it send remote fault sequences back to the link partner. A received remote fault makes it send idle columns. A second two-bit status tells the transmit client which override applies to the column now on the transmit bus.

Top module: `lf_link_fault_unit`

## Requirements
- R1: While reset is asserted and right after it, both status outputs read 00 and the transmit bus carries an idle column (data 32'h07070707, control 4'b1111).
- R2: A receive column counts as a fault sequence only when control is 4'b0001, bits 7:0 are 8'h9C and bits 23:8 are zero. Bits 31:24 equal to 8'h01 mark a local fault and 8'h02 a remote fault. Any other column, including a wrong control pattern, a nonzero middle lane or another lane-3 code, is not counted.
- R3: Four fault sequences of the same type, with the fourth no more than 127 columns after the first, declare that fault. The receive status then shows 01 for local or 10 for remote from the clock edge that samples the fourth sequence.
- R4: A sequence that arrives 128 or more columns after the first sequence of the current group starts a new group with a count of one. Offsets 0, 1, 2, 128 therefore declare nothing.
- R5: A sequence of the other type restarts the count with that type, so an interleaved pattern does not accumulate.
- R6: An active fault returns to 00 at the edge that samples the 128th consecutive column without any fault sequence. A sequence of either type restarts that count.
- R7: While the receive status is local fault, each transmitted column is 32'h0200009C with control 4'b0001 (a remote fault sequence, 8'h9C in bits 7:0).
- R8: While the receive status is remote fault, each transmitted column is an idle column.
- R9: While no fault is active, the client column appears unchanged on the transmit bus one clock after it is sampled.
- R10: The transmit status equals the receive status delayed by one clock, so it describes the column currently on the transmit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock for both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_col_data | input | 32 | Received XGMII data, lane 0 in bits 7:0 |
| rx_col_ctrl | input | 4 | Received XGMII control, bit n for lane n |
| cl_tx_data | input | 32 | Client transmit data |
| cl_tx_ctrl | input | 4 | Client transmit control |
| tx_col_data | output | 32 | Transmit XGMII data |
| tx_col_ctrl | output | 4 | Transmit XGMII control |
| rx_fault_status | output | 2 | Receive fault status: 00 none, 01 local, 10 remote |
| tx_fault_status | output | 2 | Fault status applied to the column on the transmit bus |

## Verification
A sequence counter or window counter that is off by one changes the column on which the receive status first shows a fault. The error appears within one clock of the fourth sequence and is caught by spacing that lands exactly on offsets 127 and 128. A clear counter that counts wrongly moves the drop back to 00 by whole columns around the 128th quiet column. An interrupting sequence that fails to reset it clears the status too early. A wrong override state shows on the transmit bus in the very next column, as a client word where a remote fault or idle column belongs, or as a one-column shift between the transmit status and the bus.

// File: rtl/lf_pkg.sv
package lf_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    LF_NONE   = 2'b00,
    LF_LOCAL  = 2'b01,
    LF_REMOTE = 2'b10
  } lf_status_e;

  localparam logic [7:0]        SEQ_CHAR  = 8'h9C;
  localparam logic [7:0]        IDLE_CHAR = 8'h07;
  localparam logic [LANES-1:0]  SEQ_CTRL  = 4'b0001;
  localparam logic [LANES-1:0]  IDLE_CTRL = 4'b1111;

  // Classify one received column; LF_NONE when it is no fault sequence.
  function automatic lf_status_e lf_classify(input logic [DATA_W-1:0] d,
                                             input logic [LANES-1:0]  c);
    lf_status_e k;
    k = LF_NONE;
    if (c == SEQ_CTRL && d[7:0] == SEQ_CHAR && d[23:8] == 16'h0000) begin
      if (d[31:24] == 8'h01)      k = LF_LOCAL;
      else if (d[31:24] == 8'h02) k = LF_REMOTE;
    end
    return k;
  endfunction

  // Build the sequence column for a given fault type.
  function automatic logic [DATA_W-1:0] lf_seq_col(input lf_status_e k);
    return {6'b000000, k, 16'h0000, SEQ_CHAR};
  endfunction

  function automatic logic [DATA_W-1:0] lf_idle_col();
    return {LANES{IDLE_CHAR}};
  endfunction

endpackage

// File: rtl/lf_col_decode.sv
module lf_col_decode
  import lf_pkg::*;
(
  input  logic [DATA_W-1:0] col_data,
  input  logic [LANES-1:0]  col_ctrl,
  output logic              seq_hit,
  output lf_status_e        seq_kind
);

  always_comb begin
    seq_kind = lf_classify(col_data, col_ctrl);
    seq_hit  = (seq_kind != LF_NONE);
  end

  // R2
  always_comb begin
    seq_hit_ctrl_chk: assert (!seq_hit || col_ctrl == SEQ_CTRL);
  end

endmodule

// File: rtl/lf_fault_monitor.sv
module lf_fault_monitor
  import lf_pkg::*;
#(
  parameter int DECL_COUNT = 4,
  parameter int WIN_COLS   = 128,
  parameter int CLEAR_COLS = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_hit,
  input  lf_status_e seq_kind,
  output lf_status_e status_o
);

  localparam int CNT_W = $clog2(DECL_COUNT + 1);
  localparam int WIN_W = $clog2(WIN_COLS + 1);
  localparam int CLR_W = (CLEAR_COLS > 1) ? $clog2(CLEAR_COLS) : 1;

  lf_status_e       status_q;
  lf_status_e       kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIN_W-1:0] win_q;
  logic [CLR_W-1:0] clr_q;

  // Named internal events for the assertions.
  logic             win_expired;
  logic             restart_hit;
  logic             decl_hit;
  logic             clear_hit;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    win_expired = (win_q >= WIN_W'(WIN_COLS));
    restart_hit = seq_hit && (cnt_q == '0 || seq_kind != kind_q || win_expired);
    cnt_nxt     = restart_hit ? CNT_W'(1) : cnt_q + CNT_W'(1);
    decl_hit    = seq_hit && (cnt_nxt == CNT_W'(DECL_COUNT));
    clear_hit   = (status_q != LF_NONE) && !seq_hit &&
                  (clr_q == CLR_W'(CLEAR_COLS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= LF_NONE;
      kind_q   <= LF_NONE;
      cnt_q    <= '0;
      win_q    <= '0;
      clr_q    <= '0;
    end else if (seq_hit) begin
      clr_q  <= '0;
      kind_q <= seq_kind;
      win_q  <= restart_hit ? WIN_W'(1) : (win_expired ? win_q : win_q + WIN_W'(1));
      if (decl_hit) begin
        status_q <= seq_kind;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end else begin
      if (cnt_q != '0 && !win_expired) win_q <= win_q + WIN_W'(1);
      if (clear_hit) begin
        status_q <= LF_NONE;
        clr_q    <= '0;
      end else if (status_q != LF_NONE) begin
        clr_q <= clr_q + CLR_W'(1);
      end
    end
  end

  assign status_o = status_q;

  // R3
  no_decl_without_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == LF_NONE && !seq_hit) |=> status_q == LF_NONE);

  // R6
  no_clear_on_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != LF_NONE && seq_hit) |=> status_q != LF_NONE);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(DECL_COUNT));

  // R5
  kind_follows_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hit |=> kind_q == $past(seq_kind));

endmodule

// File: rtl/lf_tx_override.sv
module lf_tx_override
  import lf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  lf_status_e        status_i,
  input  logic [DATA_W-1:0] cl_data_i,
  input  logic [LANES-1:0]  cl_ctrl_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [LANES-1:0]  tx_ctrl_o,
  output lf_status_e        tx_status_o
);

  logic [DATA_W-1:0] sel_data;
  logic [LANES-1:0]  sel_ctrl;

  always_comb begin
    unique case (status_i)
      LF_LOCAL: begin
        sel_data = lf_seq_col(LF_REMOTE);
        sel_ctrl = SEQ_CTRL;
      end
      LF_REMOTE: begin
        sel_data = lf_idle_col();
        sel_ctrl = IDLE_CTRL;
      end
      default: begin
        sel_data = cl_data_i;
        sel_ctrl = cl_ctrl_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data_o   <= lf_idle_col();
      tx_ctrl_o   <= IDLE_CTRL;
      tx_status_o <= LF_NONE;
    end else begin
      tx_data_o   <= sel_data;
      tx_ctrl_o   <= sel_ctrl;
      tx_status_o <= status_i;
    end
  end

  // R7
  local_sends_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_i == LF_LOCAL |=> (tx_ctrl_o == 4'b0001 && tx_data_o == 32'h0200009C));

  // R8
  remote_sends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_i == LF_REMOTE |=> (tx_ctrl_o == 4'b1111 && tx_data_o == 32'h07070707));

  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_i == LF_NONE |=> (tx_data_o == $past(cl_data_i) && tx_ctrl_o == $past(cl_ctrl_i)));

endmodule

// File: rtl/lf_link_fault_unit.sv
module lf_link_fault_unit
  import lf_pkg::*;
#(
  parameter int DECL_COUNT = 4,
  parameter int WIN_COLS   = 128,
  parameter int CLEAR_COLS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] rx_col_data,
  input  logic [3:0]  rx_col_ctrl,
  input  logic [31:0] cl_tx_data,
  input  logic [3:0]  cl_tx_ctrl,
  output logic [31:0] tx_col_data,
  output logic [3:0]  tx_col_ctrl,
  output logic [1:0]  rx_fault_status,
  output logic [1:0]  tx_fault_status
);

  logic       seq_hit;
  lf_status_e seq_kind;
  lf_status_e rx_status;
  lf_status_e tx_status;

  lf_col_decode u_decode (
    .col_data (rx_col_data),
    .col_ctrl (rx_col_ctrl),
    .seq_hit  (seq_hit),
    .seq_kind (seq_kind)
  );

  lf_fault_monitor #(
    .DECL_COUNT (DECL_COUNT),
    .WIN_COLS   (WIN_COLS),
    .CLEAR_COLS (CLEAR_COLS)
  ) u_monitor (
    .clk      (clk),
    .rst_n    (rst_n),
    .seq_hit  (seq_hit),
    .seq_kind (seq_kind),
    .status_o (rx_status)
  );

  lf_tx_override u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_i    (rx_status),
    .cl_data_i   (cl_tx_data),
    .cl_ctrl_i   (cl_tx_ctrl),
    .tx_data_o   (tx_col_data),
    .tx_ctrl_o   (tx_col_ctrl),
    .tx_status_o (tx_status)
  );

  assign rx_fault_status = rx_status;
  assign tx_fault_status = tx_status;

  // R10
  tx_status_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_fault_status == $past(rx_fault_status));

endmodule

// File: tb/lf_link_fault_unit_tb.sv
module lf_link_fault_unit_tb_top;

  localparam logic [31:0] LOC_COL  = 32'h0100009C;
  localparam logic [31:0] REM_COL  = 32'h0200009C;
  localparam logic [31:0] IDLE_COL = 32'h07070707;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_col_data = IDLE_COL;
  logic [3:0]  rx_col_ctrl = 4'hF;
  logic [31:0] cl_tx_data = '0;
  logic [3:0]  cl_tx_ctrl = '0;
  logic [31:0] tx_col_data;
  logic [3:0]  tx_col_ctrl;
  logic [1:0]  rx_fault_status;
  logic [1:0]  tx_fault_status;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lf_link_fault_unit dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .rx_col_data     (rx_col_data),
    .rx_col_ctrl     (rx_col_ctrl),
    .cl_tx_data      (cl_tx_data),
    .cl_tx_ctrl      (cl_tx_ctrl),
    .tx_col_data     (tx_col_data),
    .tx_col_ctrl     (tx_col_ctrl),
    .rx_fault_status (rx_fault_status),
    .tx_fault_status (tx_fault_status)
  );

  // Vector: [15:14] kind (1 local, 2 remote), [13:6] spacing, [5:2] count, [1:0] expected status
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd1, 8'd1,  4'd4, 2'b01},
    {2'd2, 8'd1,  4'd4, 2'b10},
    {2'd1, 8'd42, 4'd4, 2'b01},
    {2'd1, 8'd43, 4'd4, 2'b00},
    {2'd1, 8'd1,  4'd3, 2'b00},
    {2'd2, 8'd30, 4'd4, 2'b10}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] rd, input logic [3:0] rc,
                      input logic [31:0] td, input logic [3:0] tc);
    rx_col_data = rd;
    rx_col_ctrl = rc;
    cl_tx_data  = td;
    cl_tx_ctrl  = tc;
    @(posedge clk);
    #1;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(IDLE_COL, 4'hF, 32'h0, 4'h0);
  endtask

  task automatic seq_n(input logic [31:0] col, input int n);
    for (int i = 0; i < n; i++) step(col, 4'b0001, 32'h0, 4'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_col_data = IDLE_COL;
    rx_col_ctrl = 4'hF;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 rx status", rx_fault_status, 2'b00);
    check("R1 tx status", tx_fault_status, 2'b00);
    check("R1 tx data", tx_col_data, IDLE_COL);
    check("R1 tx ctrl", tx_col_ctrl, 4'hF);
    rst_n = 1'b1;

    // R3 R4: table of spacings
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] col;
      int sp;
      int n;
      do_reset();
      col = (VEC[v][15:14] == 2'd1) ? LOC_COL : REM_COL;
      sp  = int'(VEC[v][13:6]);
      n   = int'(VEC[v][5:2]);
      for (int s = 0; s < n; s++) begin
        seq_n(col, 1);
        if (s < n - 1) begin
          check("R3 no early status", rx_fault_status, 2'b00);
          idle_n(sp - 1);
        end
      end
      check("R3 R4 status after group", rx_fault_status, VEC[v][1:0]);
    end

    // R4: fourth at offset 127 declares, at offset 128 does not
    do_reset();
    seq_n(LOC_COL, 3);
    idle_n(124);
    seq_n(LOC_COL, 1);
    check("R4 offset 127 declares", rx_fault_status, 2'b01);
    do_reset();
    seq_n(LOC_COL, 3);
    idle_n(125);
    seq_n(LOC_COL, 1);
    check("R4 offset 128 restarts", rx_fault_status, 2'b00);

    // R2: near-miss columns are not counted
    do_reset();
    for (int i = 0; i < 8; i++) step(LOC_COL, 4'b0011, 32'h0, 4'h0);
    check("R2 wrong ctrl", rx_fault_status, 2'b00);
    for (int i = 0; i < 8; i++) step(32'h0300009C, 4'b0001, 32'h0, 4'h0);
    check("R2 lane3 code 03", rx_fault_status, 2'b00);
    for (int i = 0; i < 8; i++) step(32'h0100019C, 4'b0001, 32'h0, 4'h0);
    check("R2 middle lane nonzero", rx_fault_status, 2'b00);
    for (int i = 0; i < 8; i++) step(32'h010000FB, 4'b0001, 32'h0, 4'h0);
    check("R2 lane0 not 9C", rx_fault_status, 2'b00);

    // R5: interleaved types restart the count
    do_reset();
    seq_n(LOC_COL, 3);
    seq_n(REM_COL, 1);
    seq_n(LOC_COL, 3);
    check("R5 interleave no declare", rx_fault_status, 2'b00);
    seq_n(LOC_COL, 1);
    check("R5 fourth after restart", rx_fault_status, 2'b01);

    // R6: clearing after 128 quiet columns
    idle_n(127);
    check("R6 still active at 127", rx_fault_status, 2'b01);
    idle_n(1);
    check("R6 cleared at 128", rx_fault_status, 2'b00);
    seq_n(LOC_COL, 4);
    idle_n(100);
    seq_n(REM_COL, 1);
    idle_n(127);
    check("R6 sequence restarts clear", rx_fault_status, 2'b01);
    idle_n(1);
    check("R6 cleared after restart", rx_fault_status, 2'b00);

    // R9: passthrough
    do_reset();
    step(IDLE_COL, 4'hF, 32'hDEADBEEF, 4'h5);
    check("R9 data pass", tx_col_data, 32'hDEADBEEF);
    check("R9 ctrl pass", tx_col_ctrl, 4'h5);
    step(IDLE_COL, 4'hF, 32'h12345678, 4'h0);
    check("R9 second pattern", {tx_col_ctrl, tx_col_data}, {4'h0, 32'h12345678});

    // R7 R10: local fault override and status lag
    do_reset();
    seq_n(LOC_COL, 3);
    step(LOC_COL, 4'b0001, 32'hCAFE0001, 4'h0);
    check("R10 rx status now local", rx_fault_status, 2'b01);
    check("R10 tx status lags", tx_fault_status, 2'b00);
    check("R9 last client column", tx_col_data, 32'hCAFE0001);
    step(IDLE_COL, 4'hF, 32'h11223344, 4'h0);
    check("R7 rf data", tx_col_data, REM_COL);
    check("R7 rf ctrl", tx_col_ctrl, 4'b0001);
    check("R10 tx status local", tx_fault_status, 2'b01);

    // R8: remote fault sends idle
    do_reset();
    seq_n(REM_COL, 4);
    step(IDLE_COL, 4'hF, 32'hA5A5A5A5, 4'h0);
    check("R8 idle data", tx_col_data, IDLE_COL);
    check("R8 idle ctrl", tx_col_ctrl, 4'hF);
    check("R10 tx status remote", tx_fault_status, 2'b10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule